// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for every received CAN frame header, whether the frame should be kept. A 32-bit acceptance code and a 32-bit acceptance mask are compared against a word built from the frame's identifier, its remote flag and its leading data bytes. A mask bit set to 1 makes the matching code bit a don't-care. A mask bit set to 0 requires the frame bit to equal the code bit.

A mode bit chooses how that 32-bit word is laid out. In single mode there is one wide filter, with separate layouts for standard and extended frames. In dual mode there are two narrow filters, and the frame is kept when either of them matches.

The receive path strobes the decoded header in for one cycle. One cycle later the block returns a registered keep/drop verdict together with a one-cycle done pulse. The code, mask and mode registers are loaded through simple write strobes that share one data bus.

Top module: `rxhdr_accept_filter`

## Requirements
- R1: After reset the code is 0, the mask is all ones and the mode is dual (0). Both `res_done` and `res_accept` read 0, and every frame is then accepted.
- R2: For each compared bit, a mask bit of 1 means the bit is not checked. A mask bit of 0 requires the frame bit to equal the code bit.
- R3: In single mode (mode = 1), a standard frame (`hdr_ext` = 0) is compared as follows:
  - identifier bits 10:0 at word bits 31:21;
  - the remote flag at bit 20;
  - the first data byte at bits 15:8;
  - the second data byte at bits 7:0.
  Bits 19:16 are not checked.
- R4: In single mode, an extended frame is compared with identifier bits 28:0 at word bits 31:3 and the remote flag at bit 2. Bits 1:0 are not checked.
- R5: In dual mode (mode = 0), filter A compares the 11-bit identifier at bits 31:21 and the remote flag at bit 20. Filter B compares the identifier at bits 15:5 and the remote flag at bit 4. The frame is accepted when A or B matches.
- R6: In dual mode, filter A also compares the first data byte: its upper nibble at bits 19:16 and its lower nibble at bits 3:0.
- R7: A data-byte field counts as matching when the frame is remote, or when its length (`hdr_len`) does not reach that byte. The first byte needs a length of 1 or more, and the second byte needs a length of 2 or more.
- R8: In dual mode, an extended frame is checked on identifier bits 28:18 in place of the 11-bit standard identifier.
- R9: `res_done` is high exactly in the cycle after a cycle with `hdr_valid` high, and `res_accept` gives that frame's verdict. Without a strobe, `res_accept` keeps its value.
- R10: Writes to code, mask (`cfg_wdata`) or mode (`cfg_wdata[0]`) take effect from the next cycle. A frame strobed in the same cycle as a write is judged with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code_we | input | 1 | Load acceptance code from `cfg_wdata` |
| cfg_mask_we | input | 1 | Load acceptance mask from `cfg_wdata` |
| cfg_mode_we | input | 1 | Load mode from `cfg_wdata[0]` (1 single, 0 dual) |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_id | input | 29 | Identifier (standard frames use bits 10:0) |
| hdr_ext | input | 1 | Extended frame flag |
| hdr_rtr | input | 1 | Remote frame flag |
| hdr_len | input | 4 | Data length code |
| hdr_db0 | input | 8 | First data byte |
| hdr_db1 | input | 8 | Second data byte |
| res_done | output | 1 | Verdict valid pulse |
| res_accept | output | 1 | 1 keep frame, 0 drop frame |

## Verification
Every verdict is due exactly one cycle after its strobe. The bench's reference model therefore computes the expected verdict at the same rising edge where the design captures the header. It then compares both outputs at the following falling edge, so no comparison depends on process order at an edge.

Register writes are applied to the model after that edge's verdict is computed. This mirrors the rule that a same-cycle write is seen only by later frames. Directed checks read the verdict at the falling edge right after each strobe and compare it with literal expected values.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STD_ID_W = 11;
  localparam int unsigned EXT_ID_W = 29;
  localparam int unsigned LEN_W    = 4;
  localparam int unsigned BYTE_W   = 8;

  // A frame word and the set of its bits that take part in a compare
  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic [WORD_W-1:0] care;
  } rxf_probe_t;

  // Every cared bit must either be masked off or equal the code bit
  function automatic logic probe_hit(rxf_probe_t p, logic [WORD_W-1:0] code,
                                     logic [WORD_W-1:0] mask);
    return &(~p.care | mask | ~(p.bits ^ code));
  endfunction

  // A data byte is compared only on a data frame whose length reaches it
  function automatic logic byte_live(logic [LEN_W-1:0] len, logic rtr,
                                     int unsigned idx);
    return !rtr && (32'(len) > idx);
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter logic [WORD_W-1:0] CODE_RST = '0,
  parameter logic [WORD_W-1:0] MASK_RST = '1,
  parameter logic              MODE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic              mask_we,
  input  logic              mode_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] code_q,
  output logic [WORD_W-1:0] mask_q,
  output logic              single_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= CODE_RST;
      mask_q   <= MASK_RST;
      single_q <= MODE_RST;
    end else begin
      if (code_we) code_q   <= wdata;
      if (mask_we) mask_q   <= wdata;
      if (mode_we) single_q <= wdata[0];
    end
  end
endmodule

// File: rtl/rxf_single_match.sv
module rxf_single_match
  import rxf_pkg::*;
(
  input  logic [EXT_ID_W-1:0] id,
  input  logic                ext,
  input  logic                rtr,
  input  logic [BYTE_W-1:0]   db0,
  input  logic [BYTE_W-1:0]   db1,
  input  logic                live0,
  input  logic                live1,
  input  logic [WORD_W-1:0]   code,
  input  logic [WORD_W-1:0]   mask,
  output logic                hit
);
  localparam int unsigned STD_ID_LSB = WORD_W - STD_ID_W;   // 21
  localparam int unsigned STD_RTR    = STD_ID_LSB - 1;      // 20
  localparam int unsigned DB0_LSB    = BYTE_W;              // 8
  localparam int unsigned EXT_ID_LSB = WORD_W - EXT_ID_W;   // 3
  localparam int unsigned EXT_RTR    = EXT_ID_LSB - 1;      // 2

  rxf_probe_t probe;

  always_comb begin
    probe = '0;
    if (ext) begin
      probe.bits[EXT_ID_LSB +: EXT_ID_W] = id;
      probe.care[EXT_ID_LSB +: EXT_ID_W] = '1;
      probe.bits[EXT_RTR]                = rtr;
      probe.care[EXT_RTR]                = 1'b1;
    end else begin
      probe.bits[STD_ID_LSB +: STD_ID_W] = id[STD_ID_W-1:0];
      probe.care[STD_ID_LSB +: STD_ID_W] = '1;
      probe.bits[STD_RTR]                = rtr;
      probe.care[STD_RTR]                = 1'b1;
      probe.bits[DB0_LSB +: BYTE_W]      = db0;
      probe.care[DB0_LSB +: BYTE_W]      = {BYTE_W{live0}};
      probe.bits[0 +: BYTE_W]            = db1;
      probe.care[0 +: BYTE_W]            = {BYTE_W{live1}};
    end
  end

  assign hit = probe_hit(probe, code, mask);
endmodule

// File: rtl/rxf_dual_match.sv
module rxf_dual_match
  import rxf_pkg::*;
#(
  parameter int unsigned ID_LSB   = 21,
  parameter int unsigned RTR_POS  = 20,
  parameter bit          USE_DATA = 1'b1
) (
  input  logic [STD_ID_W-1:0] id11,
  input  logic                rtr,
  input  logic [BYTE_W-1:0]   db0,
  input  logic                live0,
  input  logic [WORD_W-1:0]   code,
  input  logic [WORD_W-1:0]   mask,
  output logic                hit
);
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned LO_LSB = 0;

  rxf_probe_t probe;

  generate
    if (USE_DATA) begin : g_data
      always_comb begin
        probe = '0;
        probe.bits[ID_LSB +: STD_ID_W] = id11;
        probe.care[ID_LSB +: STD_ID_W] = '1;
        probe.bits[RTR_POS]            = rtr;
        probe.care[RTR_POS]            = 1'b1;
        probe.bits[HI_LSB +: NIB_W]    = db0[BYTE_W-1:NIB_W];
        probe.care[HI_LSB +: NIB_W]    = {NIB_W{live0}};
        probe.bits[LO_LSB +: NIB_W]    = db0[NIB_W-1:0];
        probe.care[LO_LSB +: NIB_W]    = {NIB_W{live0}};
      end
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{db0, live0};
      always_comb begin
        probe = '0;
        probe.bits[ID_LSB +: STD_ID_W] = id11;
        probe.care[ID_LSB +: STD_ID_W] = '1;
        probe.bits[RTR_POS]            = rtr;
        probe.care[RTR_POS]            = 1'b1;
      end
    end
  endgenerate

  assign hit = probe_hit(probe, code, mask);
endmodule

// File: rtl/rxhdr_accept_filter.sv
module rxhdr_accept_filter
  import rxf_pkg::*;
#(
  parameter int unsigned N_DUAL = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_code_we,
  input  logic                cfg_mask_we,
  input  logic                cfg_mode_we,
  input  logic [WORD_W-1:0]   cfg_wdata,
  input  logic                hdr_valid,
  input  logic [EXT_ID_W-1:0] hdr_id,
  input  logic                hdr_ext,
  input  logic                hdr_rtr,
  input  logic [LEN_W-1:0]    hdr_len,
  input  logic [BYTE_W-1:0]   hdr_db0,
  input  logic [BYTE_W-1:0]   hdr_db1,
  output logic                res_done,
  output logic                res_accept
);
  localparam int unsigned EXT_TOP_LSB = EXT_ID_W - STD_ID_W; // 18

  logic [WORD_W-1:0]   code_q, mask_q;
  logic                single_q;
  logic                live0, live1;
  logic [STD_ID_W-1:0] id_narrow;
  logic                single_hit;
  logic [N_DUAL-1:0]   dual_hit;
  logic                frame_hit;

  rxf_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_we (cfg_code_we),
    .mask_we (cfg_mask_we),
    .mode_we (cfg_mode_we),
    .wdata   (cfg_wdata),
    .code_q  (code_q),
    .mask_q  (mask_q),
    .single_q(single_q)
  );

  assign live0     = byte_live(hdr_len, hdr_rtr, 0);
  assign live1     = byte_live(hdr_len, hdr_rtr, 1);
  assign id_narrow = hdr_ext ? hdr_id[EXT_TOP_LSB +: STD_ID_W] : hdr_id[STD_ID_W-1:0];

  rxf_single_match u_single (
    .id   (hdr_id),
    .ext  (hdr_ext),
    .rtr  (hdr_rtr),
    .db0  (hdr_db0),
    .db1  (hdr_db1),
    .live0(live0),
    .live1(live1),
    .code (code_q),
    .mask (mask_q),
    .hit  (single_hit)
  );

  // Filter g sits 16 bits below filter g-1; only the first one checks data
  genvar g;
  generate
    for (g = 0; g < N_DUAL; g++) begin : g_dual
      rxf_dual_match #(
        .ID_LSB  (WORD_W - STD_ID_W - 16 * g),
        .RTR_POS (WORD_W - STD_ID_W - 1 - 16 * g),
        .USE_DATA(g == 0)
      ) u_flt (
        .id11 (id_narrow),
        .rtr  (hdr_rtr),
        .db0  (hdr_db0),
        .live0(live0),
        .code (code_q),
        .mask (mask_q),
        .hit  (dual_hit[g])
      );
    end
  endgenerate

  assign frame_hit = single_q ? single_hit : |dual_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done   <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_done <= hdr_valid;
      if (hdr_valid) res_accept <= frame_hit;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        cfg_mode_we,
  input logic        cfg_wdata0,
  input logic        res_done,
  input logic        res_accept,
  input logic [31:0] mask_q,
  input logic        single_q,
  input logic [1:0]  dual_hit
);
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_done);
  a_r9_no_done_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_done);
  a_r9_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> $stable(res_accept));
  a_r2_all_masked_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && (&mask_q)) |=> res_accept);
  a_r5_dual_either_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !single_q && (dual_hit != 2'b00)) |=> res_accept);
  a_r5_dual_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !single_q && (dual_hit == 2'b00)) |=> !res_accept);
  a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_we |=> (single_q == $past(cfg_wdata0)));
endmodule

bind rxhdr_accept_filter rxf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hdr_valid  (hdr_valid),
  .cfg_mode_we(cfg_mode_we),
  .cfg_wdata0 (cfg_wdata[0]),
  .res_done   (res_done),
  .res_accept (res_accept),
  .mask_q     (mask_q),
  .single_q   (single_q),
  .dual_hit   (dual_hit)
);

// File: tb/sim_rxhdr_accept_filter.sv
`timescale 1ns/1ps
module sim_rxhdr_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_code_we = 1'b0, cfg_mask_we = 1'b0, cfg_mode_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        hdr_valid = 1'b0;
  logic [28:0] hdr_id = '0;
  logic        hdr_ext = 1'b0, hdr_rtr = 1'b0;
  logic [3:0]  hdr_len = '0;
  logic [7:0]  hdr_db0 = '0, hdr_db1 = '0;
  logic        res_done, res_accept;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_code, m_mask;
  bit          m_single;
  bit          exp_done, exp_acc;
  string       exp_tag = "R1";

  always #5 clk = ~clk;

  rxhdr_accept_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_code_we(cfg_code_we), .cfg_mask_we(cfg_mask_we), .cfg_mode_we(cfg_mode_we),
    .cfg_wdata(cfg_wdata),
    .hdr_valid(hdr_valid), .hdr_id(hdr_id), .hdr_ext(hdr_ext), .hdr_rtr(hdr_rtr),
    .hdr_len(hdr_len), .hdr_db0(hdr_db0), .hdr_db1(hdr_db1),
    .res_done(res_done), .res_accept(res_accept)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Does a code field hi..lo hold value v under the don't-care mask?
  function automatic bit fld(logic [31:0] c, logic [31:0] m, int hi, int lo, logic [31:0] v);
    for (int b = lo; b <= hi; b++)
      if (!m[b] && (c[b] != v[b-lo])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ref_accept(logic [31:0] c, logic [31:0] m, bit single,
                                    logic [28:0] id, bit ext, bit rtr, int len,
                                    logic [7:0] d0, logic [7:0] d1);
    bit skip0 = rtr || (len < 1);
    bit skip1 = rtr || (len < 2);
    logic [10:0] top;
    bit fa, fb;
    if (single) begin
      if (ext) return fld(c, m, 31, 3, 32'(id)) && fld(c, m, 2, 2, 32'(rtr));
      return fld(c, m, 31, 21, 32'(id[10:0])) && fld(c, m, 20, 20, 32'(rtr)) &&
             (skip0 || fld(c, m, 15, 8, 32'(d0))) && (skip1 || fld(c, m, 7, 0, 32'(d1)));
    end
    top = ext ? id[28:18] : id[10:0];
    fa = fld(c, m, 31, 21, 32'(top)) && fld(c, m, 20, 20, 32'(rtr)) &&
         (skip0 || (fld(c, m, 19, 16, 32'(d0[7:4])) && fld(c, m, 3, 0, 32'(d0[3:0]))));
    fb = fld(c, m, 15, 5, 32'(top)) && fld(c, m, 4, 4, 32'(rtr));
    return fa || fb;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = '0; m_mask = '1; m_single = 1'b0;
      exp_done = 1'b0; exp_acc = 1'b0;
    end else begin
      exp_done = hdr_valid;
      if (hdr_valid) begin
        exp_acc = ref_accept(m_code, m_mask, m_single, hdr_id, hdr_ext, hdr_rtr,
                             int'(hdr_len), hdr_db0, hdr_db1);
        exp_tag = cur_req;
      end
      if (cfg_code_we) m_code = cfg_wdata;
      if (cfg_mask_we) m_mask = cfg_wdata;
      if (cfg_mode_we) m_single = cfg_wdata[0];
    end
  end

  // per-cycle comparison against the model (R9 timing, verdict per tag)
  always @(negedge clk) begin
    if (chk_on) begin
      chk(res_done == exp_done, "R9", int'(res_done), int'(exp_done));
      if (exp_done) chk(res_accept == exp_acc, exp_tag, int'(res_accept), int'(exp_acc));
    end
  end

  task automatic wr(int sel, logic [31:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_code_we = (sel == 0); cfg_mask_we = (sel == 1); cfg_mode_we = (sel == 2);
    @(negedge clk);
    cfg_code_we = 1'b0; cfg_mask_we = 1'b0; cfg_mode_we = 1'b0;
  endtask

  task automatic send(logic [28:0] id, bit ext, bit rtr, logic [3:0] len,
                      logic [7:0] d0, logic [7:0] d1);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = id; hdr_ext = ext; hdr_rtr = rtr;
    hdr_len = len; hdr_db0 = d0; hdr_db1 = d1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  // directed verdict check, sampled at the falling edge after the strobe
  task automatic expect_acc(bit e, string req);
    chk(res_accept == e && res_done, req, int'(res_accept), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    chk(res_done == 1'b0, "R1", int'(res_done), 0);
    chk(res_accept == 1'b0, "R1", int'(res_accept), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    cur_req = "R1";
    send(29'h7FF, 1'b0, 1'b0, 4'd8, 8'h12, 8'h34); expect_acc(1'b1, "R1");
    send(29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 8'h00, 8'h00); expect_acc(1'b1, "R1");

    // R3: single standard layout
    cur_req = "R3";
    wr(2, 32'h1);
    wr(0, (32'h123 << 21) | 32'h0000A53C);
    wr(1, 32'h000F0000);
    send(29'h123, 1'b0, 1'b0, 4'd8, 8'hA5, 8'h3C); expect_acc(1'b1, "R3");
    send(29'h124, 1'b0, 1'b0, 4'd8, 8'hA5, 8'h3C); expect_acc(1'b0, "R3");
    send(29'h123, 1'b0, 1'b0, 4'd8, 8'hA4, 8'h3C); expect_acc(1'b0, "R3");
    send(29'h123, 1'b0, 1'b0, 4'd8, 8'hA5, 8'h3D); expect_acc(1'b0, "R3");

    // R7: data fields skipped for short or remote frames
    cur_req = "R7";
    send(29'h123, 1'b0, 1'b0, 4'd1, 8'hA5, 8'hFF); expect_acc(1'b1, "R7");
    send(29'h123, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00); expect_acc(1'b1, "R7");
    send(29'h123, 1'b0, 1'b1, 4'd8, 8'h00, 8'h00); expect_acc(1'b0, "R7");
    wr(1, 32'h001F0000);
    send(29'h123, 1'b0, 1'b1, 4'd8, 8'h00, 8'h00); expect_acc(1'b1, "R7");

    // R2: masked identifier bit
    cur_req = "R2";
    wr(1, 32'h003F0000);
    send(29'h122, 1'b0, 1'b0, 4'd2, 8'hA5, 8'h3C); expect_acc(1'b1, "R2");
    send(29'h121, 1'b0, 1'b0, 4'd2, 8'hA5, 8'h3C); expect_acc(1'b0, "R2");

    // R4: single extended layout
    cur_req = "R4";
    wr(0, {29'h1ABCDEF5, 3'b000});
    wr(1, 32'h00000003);
    send(29'h1ABCDEF5, 1'b1, 1'b0, 4'd8, 8'h00, 8'h00); expect_acc(1'b1, "R4");
    send(29'h1ABCDEF4, 1'b1, 1'b0, 4'd8, 8'h00, 8'h00); expect_acc(1'b0, "R4");
    send(29'h1ABCDEF5, 1'b1, 1'b1, 4'd0, 8'h00, 8'h00); expect_acc(1'b0, "R4");

    // R5 / R6 / R8: dual mode
    cur_req = "R5";
    wr(2, 32'h0);
    wr(0, (32'h055 << 21) | (32'h9 << 16) | (32'h2AA << 5) | 32'h6);
    wr(1, 32'h0);
    send(29'h055, 1'b0, 1'b0, 4'd1, 8'h96, 8'h00); expect_acc(1'b1, "R5");
    send(29'h2AA, 1'b0, 1'b0, 4'd4, 8'h00, 8'h00); expect_acc(1'b1, "R5");
    send(29'h100, 1'b0, 1'b0, 4'd1, 8'h96, 8'h00); expect_acc(1'b0, "R5");
    cur_req = "R6";
    send(29'h055, 1'b0, 1'b0, 4'd1, 8'h97, 8'h00); expect_acc(1'b0, "R6");
    send(29'h055, 1'b0, 1'b0, 4'd1, 8'h86, 8'h00); expect_acc(1'b0, "R6");
    cur_req = "R7";
    send(29'h055, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00); expect_acc(1'b1, "R7");
    cur_req = "R8";
    send((29'h2AA << 18) | 29'h3FFFF, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00); expect_acc(1'b1, "R8");
    send(29'h055, 1'b1, 1'b0, 4'd0, 8'h00, 8'h00); expect_acc(1'b0, "R8");

    // R10: write in the same cycle as a frame uses the old mask
    cur_req = "R10";
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = 29'h100; hdr_ext = 1'b0; hdr_rtr = 1'b0; hdr_len = 4'd0;
    cfg_mask_we = 1'b1; cfg_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    hdr_valid = 1'b0; cfg_mask_we = 1'b0;
    expect_acc(1'b0, "R10");
    send(29'h100, 1'b0, 1'b0, 4'd0, 8'h00, 8'h00); expect_acc(1'b1, "R10");

    // R9: back-to-back strobes then idle, verdict held
    cur_req = "R9";
    wr(1, 32'h0);
    @(negedge clk); hdr_valid = 1'b1; hdr_id = 29'h2AA; hdr_len = 4'd0;
    @(negedge clk); hdr_id = 29'h3FF;
    @(negedge clk); hdr_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_accept == 1'b0 && !res_done, "R9", int'(res_accept), 0);

    // R2: randomised sweep compared against the model on every clock
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) begin
        wr(0, $urandom);
        wr(1, $urandom | $urandom | $urandom);
        wr(2, 32'($urandom % 2));
      end
      send(29'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
           8'($urandom), 8'($urandom));
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule